// File: doc/BRIEF.md
# Whole-Track Format Write Byte Engine

This block is the byte-level data path of a floppy controller's whole-track write, the command used to format a double-density track. A command byte starts it. After an optional head-settle wait and the next index pulse, it writes one byte each time the downstream serializer strobes `byte_tick`. It asks the host for every byte with a data-request flag. It does not copy the host stream verbatim. A few reserved values become missing-clock address marks, a CRC preset, or a two-byte CRC emission, so that ID and data fields carry valid checksums.

The block keeps a CRC-16 accumulator (polynomial 0x1021, MSB first) over the bytes it writes. Each output byte carries a flag telling the bit encoder whether to drop a clock bit to form a mark. If the host misses a request, the block writes a zero byte and records a lost-data condition. The track ends at the following index pulse, which raises the completion interrupt. A write-protected medium ends the command at once and nothing is written.

Top module: `fmt_track_writer`

## Requirements
- R1: A command byte is accepted only while idle and only when it matches 1111_0E00 (bits 7..4 all one, bits 3, 1 and 0 zero, bit 2 = E). Any other value, or any command while busy, has no effect.
- R2: If `wprot_in` is high when a valid command arrives, `intrq` and `wprot_err` rise on the next cycle, `busy` stays low and `wr_gate` never rises.
- R3: `drq` rises when a command is accepted and again each time a host byte is consumed. A host write while busy clears it. `drq` is low whenever the block is idle.
- R4: Writing (`wr_gate` high) begins on the first active index edge in the wait state. No `byte_tick` before then produces output.
- R5: With E = 1, index edges during the SETTLE_CYCLES clock cycles after acceptance are ignored. The first index edge after that window starts writing.
- R6: Host value F5 is written as A1 with the mark flag set. The CRC is preset to FFFF and then absorbs that A1.
- R7: Host value F6 is written as C2 with the mark flag set, and C2 is absorbed into the CRC.
- R8: Host value F7 writes the CRC high byte on that tick and the low byte on the next tick, both without mark. The second tick consumes no host byte, and the CRC bytes are not absorbed.
- R9: Every other host value, including FB, FE, F8..FD and ordinary data, is written unchanged without mark and absorbed into the CRC.
- R10: A tick that finds `drq` still high writes 00 and sets `lost_data`. The flag holds until the next command that starts writing.
- R11: The next active index edge while writing ends the command: `busy`, `drq` and `wr_gate` fall and `intrq` rises in the same cycle. A new accepted command clears `intrq`.
- R12: `out_valid` pulses for exactly one cycle, in the cycle after the `byte_tick` it serves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command code |
| host_wr | input | 1 | Host writes the data byte |
| host_data | input | 8 | Host data byte |
| index_in | input | 1 | Index pulse from drive (polarity by parameter, default active low) |
| wprot_in | input | 1 | Medium write-protected |
| byte_tick | input | 1 | Serializer wants the next byte |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data byte requested from host |
| intrq | output | 1 | Command completed |
| lost_data | output | 1 | A request went unserviced |
| wprot_err | output | 1 | Command refused for write protect |
| wr_gate | output | 1 | Write gate to the drive |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Byte to be encoded |
| out_mark | output | 1 | Encode this byte with a missing clock |

## Verification
A CRC accumulator left in the wrong state stays hidden until the next F7. It then shows as a wrong high byte in the cycle after that tick, so the vector table places an F7 after every group of marks and data. A wrong mapping or mark flag shows in `out_byte`/`out_mark` one cycle after its tick. A stuck pending-low flag shows as a host byte missing or repeated on the tick after a CRC. Faults in sequencing, such as an early start during settle or a missed end on index, show in `wr_gate`, `busy` and `intrq` within one cycle of the index edge.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   localparam int BYTE_W = 8;
   localparam int CRC_W  = 16;

   localparam logic [BYTE_W-1:0] HOST_PRESET = 8'hF5;
   localparam logic [BYTE_W-1:0] HOST_IDXMK  = 8'hF6;
   localparam logic [BYTE_W-1:0] HOST_CRC    = 8'hF7;
   localparam logic [BYTE_W-1:0] MARK_SYNC   = 8'hA1;
   localparam logic [BYTE_W-1:0] MARK_INDEX  = 8'hC2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_WAIT_IDX,
      ST_WRITE
   } fmt_state_t;

   typedef enum logic [1:0] {
      ACT_LIT,
      ACT_PRESET,
      ACT_CRC
   } byte_act_t;

   typedef struct packed {
      logic [BYTE_W-1:0] val;
      logic              mark;
      byte_act_t         act;
   } byte_plan_t;
endpackage

// File: rtl/fmt_byte_map.sv
module fmt_byte_map
   import fmt_pkg::*;
(
   input  logic [BYTE_W-1:0] src,
   output byte_plan_t        plan
);
   always_comb begin
      plan.val  = src;
      plan.mark = 1'b0;
      plan.act  = ACT_LIT;
      unique case (src)
         HOST_PRESET: begin
            plan.val  = MARK_SYNC;
            plan.mark = 1'b1;
            plan.act  = ACT_PRESET;
         end
         HOST_IDXMK: begin
            plan.val  = MARK_INDEX;
            plan.mark = 1'b1;
         end
         HOST_CRC: begin
            plan.act  = ACT_CRC;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fmt_crc16.sv
module fmt_crc16 #(
   parameter int               CRC_W  = 16,
   parameter int               DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 16'h1021,
   parameter logic [CRC_W-1:0] INIT   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset,
   input  logic              absorb,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] stage [0:DATA_W];

   if (CRC_W < 2) begin : g_bad_width
      $error("fmt_crc16: CRC_W must be at least 2");
   end

   assign base     = preset ? INIT : crc_q;
   assign stage[0] = base;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0}
                        ^ ((stage[g][CRC_W-1] ^ din[DATA_W-1-g]) ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= INIT;
      else if (preset || absorb)
         crc_q <= absorb ? stage[DATA_W] : base;
   end

   assign crc = crc_q;
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
   import fmt_pkg::*;
#(
   parameter int SETTLE_CYCLES  = 30000,
   parameter bit IDX_LOW_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              index_in,
   input  logic              wprot_in,
   output logic              busy,
   output logic              intrq,
   output logic              wprot_err,
   output logic              wr_gate,
   output logic              start_o,
   output logic              stop_o
);
   localparam int             CNT_W    = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("fmt_seq: SETTLE_CYCLES must be at least 1");
   end

   fmt_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             idx_act, idx_q, idx_edge, cmd_hit, want_settle;

   if (IDX_LOW_ACTIVE) begin : g_idx_low
      assign idx_act = ~index_in;
   end else begin : g_idx_high
      assign idx_act = index_in;
   end

   assign cmd_hit     = cmd_valid && (cmd_byte[7:4] == 4'hF) && !cmd_byte[3]
                        && (cmd_byte[1:0] == 2'b00);
   assign want_settle = cmd_byte[2];
   assign idx_edge    = idx_act & ~idx_q;
   assign start_o     = cmd_hit && (st_q == ST_IDLE) && !wprot_in;
   assign stop_o      = (st_q == ST_WRITE) && idx_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         idx_q     <= 1'b0;
         intrq     <= 1'b0;
         wprot_err <= 1'b0;
      end else begin
         idx_q <= idx_act;
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_hit) begin
                  if (wprot_in) begin
                     intrq     <= 1'b1;
                     wprot_err <= 1'b1;
                  end else begin
                     intrq     <= 1'b0;
                     wprot_err <= 1'b0;
                     cnt_q     <= '0;
                     st_q      <= want_settle ? ST_SETTLE : ST_WAIT_IDX;
                  end
               end
            end
            ST_SETTLE: begin
               if (cnt_q == CNT_LAST)
                  st_q <= ST_WAIT_IDX;
               else
                  cnt_q <= cnt_q + CNT_W'(1);
            end
            ST_WAIT_IDX: begin
               if (idx_edge)
                  st_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (idx_edge) begin
                  st_q  <= ST_IDLE;
                  intrq <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != ST_IDLE);
   assign wr_gate = (st_q == ST_WRITE);
endmodule

// File: rtl/fmt_track_writer.sv
module fmt_track_writer
   import fmt_pkg::*;
#(
   parameter int               SETTLE_CYCLES  = 30000,
   parameter bit               IDX_LOW_ACTIVE = 1'b1,
   parameter logic [CRC_W-1:0] CRC_POLY       = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT       = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_data,
   input  logic              index_in,
   input  logic              wprot_in,
   input  logic              byte_tick,
   output logic              busy,
   output logic              drq,
   output logic              intrq,
   output logic              lost_data,
   output logic              wprot_err,
   output logic              wr_gate,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_mark
);
   localparam int HALF = CRC_W / 2;

   if (CRC_W != 2 * BYTE_W) begin : g_bad_crc
      $error("fmt_track_writer: CRC must be two bytes wide");
   end

   logic              start_s, stop_s;
   logic [BYTE_W-1:0] data_q, src;
   logic              drq_q, lo_pend_q, lost_q;
   logic              tick_ok, consume, crc_preset, crc_absorb;
   byte_plan_t        plan;
   logic [CRC_W-1:0]  crc;

   fmt_seq #(
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .IDX_LOW_ACTIVE(IDX_LOW_ACTIVE)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_byte (cmd_byte),
      .index_in (index_in),
      .wprot_in (wprot_in),
      .busy     (busy),
      .intrq    (intrq),
      .wprot_err(wprot_err),
      .wr_gate  (wr_gate),
      .start_o  (start_s),
      .stop_o   (stop_s)
   );

   assign tick_ok = wr_gate && byte_tick && !stop_s;
   assign consume = tick_ok && !lo_pend_q;
   assign src     = drq_q ? '0 : data_q;

   fmt_byte_map u_map (
      .src (src),
      .plan(plan)
   );

   assign crc_preset = start_s || (consume && plan.act == ACT_PRESET);
   assign crc_absorb = consume && (plan.act != ACT_CRC);

   fmt_crc16 #(
      .CRC_W (CRC_W),
      .DATA_W(BYTE_W),
      .POLY  (CRC_POLY),
      .INIT  (CRC_INIT)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .preset(crc_preset),
      .absorb(crc_absorb),
      .din   (plan.val),
      .crc   (crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         drq_q     <= 1'b0;
         lo_pend_q <= 1'b0;
         lost_q    <= 1'b0;
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_mark  <= 1'b0;
      end else begin
         if (busy && host_wr)
            data_q <= host_data;

         if (start_s)
            drq_q <= 1'b1;
         else if (stop_s)
            drq_q <= 1'b0;
         else if (consume)
            drq_q <= 1'b1;
         else if (busy && host_wr)
            drq_q <= 1'b0;

         if (start_s)
            lost_q <= 1'b0;
         else if (consume && drq_q)
            lost_q <= 1'b1;

         if (start_s)
            lo_pend_q <= 1'b0;
         else if (tick_ok)
            lo_pend_q <= consume && (plan.act == ACT_CRC);

         out_valid <= tick_ok;
         if (tick_ok) begin
            if (lo_pend_q) begin
               out_byte <= crc[HALF-1:0];
               out_mark <= 1'b0;
            end else if (plan.act == ACT_CRC) begin
               out_byte <= crc[CRC_W-1:HALF];
               out_mark <= 1'b0;
            end else begin
               out_byte <= plan.val;
               out_mark <= plan.mark;
            end
         end
      end
   end

   assign drq       = drq_q;
   assign lost_data = lost_q;
endmodule

// File: rtl/fmt_track_writer_chk.sv
module fmt_track_writer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       drq,
   input logic       intrq,
   input logic       lost_data,
   input logic       wprot_err,
   input logic       wr_gate,
   input logic       out_valid,
   input logic [7:0] out_byte,
   input logic       out_mark
);
   AST_DRQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !drq);                                                    // R3
   AST_GATE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gate |-> busy);                                                  // R4
   AST_OUT_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(wr_gate));                                      // R12
   AST_MARK_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mark) |-> (out_byte == 8'hA1 || out_byte == 8'hC2)); // R6
   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $past(lost_data)) |-> lost_data);           // R10
   AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> intrq);                                             // R11
   AST_WPROT_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      wprot_err |-> !wr_gate);                                            // R2
endmodule

bind fmt_track_writer fmt_track_writer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .drq      (drq),
   .intrq    (intrq),
   .lost_data(lost_data),
   .wprot_err(wprot_err),
   .wr_gate  (wr_gate),
   .out_valid(out_valid),
   .out_byte (out_byte),
   .out_mark (out_mark)
);

// File: tb/fmt_track_writer_test.sv
module fmt_track_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 20;
   localparam int NVEC       = 16;
   // fields: [17:10] host byte, [9:2] expected byte, [1] mark, [0] CRC pair
   localparam logic [17:0] VEC [0:NVEC-1] = '{
      {8'h4E, 8'h4E, 1'b0, 1'b0},
      {8'h00, 8'h00, 1'b0, 1'b0},
      {8'hF5, 8'hA1, 1'b1, 1'b0},
      {8'hF5, 8'hA1, 1'b1, 1'b0},
      {8'hFE, 8'hFE, 1'b0, 1'b0},
      {8'h05, 8'h05, 1'b0, 1'b0},
      {8'hF7, 8'h00, 1'b0, 1'b1},
      {8'hF6, 8'hC2, 1'b1, 1'b0},
      {8'hFB, 8'hFB, 1'b0, 1'b0},
      {8'hF8, 8'hF8, 1'b0, 1'b0},
      {8'hF9, 8'hF9, 1'b0, 1'b0},
      {8'hFA, 8'hFA, 1'b0, 1'b0},
      {8'hFC, 8'hFC, 1'b0, 1'b0},
      {8'hFD, 8'hFD, 1'b0, 1'b0},
      {8'hE5, 8'hE5, 1'b0, 1'b0},
      {8'hF7, 8'h00, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       host_wr = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic       index_in = 1'b1;
   logic       wprot_in = 1'b0;
   logic       byte_tick = 1'b0;
   logic       busy, drq, intrq, lost_data, wprot_err, wr_gate;
   logic       out_valid, out_mark;
   logic [7:0] out_byte;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic [15:0] model_crc;

   always #(CLK_PERIOD/2) clk = ~clk;

   fmt_track_writer #(.SETTLE_CYCLES(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .host_wr(host_wr), .host_data(host_data), .index_in(index_in),
      .wprot_in(wprot_in), .byte_tick(byte_tick), .busy(busy), .drq(drq),
      .intrq(intrq), .lost_data(lost_data), .wprot_err(wprot_err),
      .wr_gate(wr_gate), .out_valid(out_valid), .out_byte(out_byte),
      .out_mark(out_mark)
   );

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++)
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic send_cmd(input logic [7:0] b);
      @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic host_put(input logic [7:0] b);
      @(negedge clk); host_wr = 1'b1; host_data = b;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic tick;
      @(negedge clk); byte_tick = 1'b1;
      @(negedge clk); byte_tick = 1'b0;
   endtask

   task automatic index_pulse;
      @(negedge clk); index_in = 1'b0;
      @(negedge clk); index_in = 1'b1;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R3 reset drq", {31'd0, drq}, 0);
      chk("R11 reset busy/intrq/gate", {29'd0, busy, intrq, wr_gate}, 0);
      chk("R12 reset out_valid", {31'd0, out_valid}, 0);

      // R1: invalid codes ignored
      send_cmd(8'hF1);
      chk("R1 code F1 ignored", {31'd0, busy}, 0);
      send_cmd(8'hF8);
      chk("R1 code F8 ignored", {31'd0, busy}, 0);
      send_cmd(8'h80);
      chk("R1 code 80 ignored", {30'd0, busy, drq}, 0);

      // R2: write protect
      wprot_in = 1'b1;
      send_cmd(8'hF0);
      chk("R2 wprot flags", {29'd0, intrq, wprot_err, busy}, 3'b110);
      index_pulse();
      chk("R2 no gate", {31'd0, wr_gate}, 0);
      wprot_in = 1'b0;

      // start without settle
      send_cmd(8'hF0);
      chk("R3 drq on accept", {29'd0, busy, drq, intrq}, 3'b110);
      chk("R2 wprot_err cleared", {31'd0, wprot_err}, 0);
      send_cmd(8'hF0);
      chk("R1 command while busy", {30'd0, busy, drq}, 2'b11);
      tick();
      chk("R4 no output before index", {31'd0, out_valid}, 0);
      index_pulse();
      chk("R4 gate after index", {31'd0, wr_gate}, 1);
      model_crc = 16'hFFFF;

      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] hb, eb;
         logic       mk, pr;
         hb = VEC[v][17:10]; eb = VEC[v][9:2]; mk = VEC[v][1]; pr = VEC[v][0];
         host_put(hb);
         chk("R3 host write clears drq", {31'd0, drq}, 0);
         tick();
         chk("R12 out_valid after tick", {31'd0, out_valid}, 1);
         chk("R3 drq after consume", {31'd0, drq}, 1);
         if (pr) begin
            chk("R8 crc high byte", {23'd0, out_mark, out_byte}, {24'd0, model_crc[15:8]});
            tick();
            chk("R8 crc low byte", {23'd0, out_mark, out_byte}, {24'd0, model_crc[7:0]});
         end else begin
            if (hb == 8'hF5) begin
               model_crc = crc_upd(16'hFFFF, 8'hA1);
               chk("R6 sync mark", {23'd0, out_mark, out_byte}, {23'd0, mk, eb});
            end else begin
               model_crc = crc_upd(model_crc, eb);
               if (hb == 8'hF6)
                  chk("R7 index mark", {23'd0, out_mark, out_byte}, {23'd0, mk, eb});
               else
                  chk("R9 literal byte", {23'd0, out_mark, out_byte}, {23'd0, mk, eb});
            end
         end
      end
      @(negedge clk);
      chk("R12 single-cycle pulse", {31'd0, out_valid}, 0);

      // R10: underrun
      tick();
      chk("R10 underrun writes zero", {24'd0, out_byte}, 0);
      chk("R10 lost set", {31'd0, lost_data}, 1);
      host_put(8'h4E);
      tick();
      chk("R10 lost sticky", {23'd0, lost_data, out_byte}, {23'd0, 1'b1, 8'h4E});

      // R11: end on index
      index_pulse();
      chk("R11 end", {28'd0, busy, drq, wr_gate, intrq}, 4'b0001);
      tick();
      chk("R11 no output after end", {31'd0, out_valid}, 0);

      // R5: settle with E=1
      send_cmd(8'hF4);
      chk("R11 intrq cleared", {31'd0, intrq}, 0);
      chk("R10 lost cleared", {31'd0, lost_data}, 0);
      index_pulse();
      chk("R5 index during settle ignored", {31'd0, wr_gate}, 0);
      repeat (SETTLE + 4) @(negedge clk);
      chk("R5 still waiting", {30'd0, busy, wr_gate}, 2'b10);
      index_pulse();
      chk("R5 gate after settle", {31'd0, wr_gate}, 1);
      host_put(8'hF5);
      tick();
      host_put(8'hF7);
      tick();
      model_crc = crc_upd(16'hFFFF, 8'hA1);
      chk("R6 preset then crc high", {24'd0, out_byte}, {24'd0, model_crc[15:8]});
      host_put(8'h33);
      tick();
      chk("R8 low byte ignores queued host byte", {24'd0, out_byte}, {24'd0, model_crc[7:0]});
      chk("R8 host byte still held", {31'd0, drq}, 0);
      tick();
      chk("R9 queued byte follows crc", {24'd0, out_byte}, 32'h33);
      index_pulse();
      chk("R11 second end", {29'd0, busy, wr_gate, intrq}, 3'b001);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule